// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for each assembled CAN frame, whether it is kept and which of two receive buffers it goes to. The identifier and the extended-format flag of the frame arrive with a one-cycle valid strobe. Six programmable filters compare them under two programmable masks. Filters 0 and 1 work under mask 0 and lead to buffer 0. Filters 2 to 5 work under mask 1 and lead to buffer 1.

Each filter has its own extended-format bit, so a standard frame is only compared with standard filters. A two-bit mode per buffer can change that rule. One clock after the strobe the block reports whether the frame is accepted, the buffer it goes to, and the index of the filter that matched. Frame reception and buffer storage are done outside this block.

Top module: `can_accept_filter`

## Requirements
- R1: Filters 0 and 1 use mask 0 and report buffer 0 (`buf_sel_o`=0). Filters 2 to 5 use mask 1 and report buffer 1 (`buf_sel_o`=1). `filt_idx_o` holds the binary filter number, from 0 to 5.
- R2: A mask bit of 0 makes that identifier bit match whatever the filter bit is. A mask bit of 1 requires the frame bit and the filter bit to be equal.
- R3: A standard frame (`frm_ide_i`=0) compares only identifier bits [10:0]. Bits [28:11] of the frame, the filter and the mask are ignored. An extended frame compares all 29 bits.
- R4: In buffer mode 2'b00, a filter can match only if its extended bit (`flt_ext_i[k]`) equals `frm_ide_i`.
- R5: In buffer mode 2'b01, only standard frames can match the filters of that buffer, and the filters' extended bits are ignored.
- R6: In buffer mode 2'b10, only extended frames can match the filters of that buffer, and the filters' extended bits are ignored.
- R7: In buffer mode 2'b11, every frame is accepted into that buffer. The reported index is the lowest filter of its group (0 or 2).
- R8: When both buffers have a match, buffer 0 is reported.
- R9: Within a buffer's group, the lowest-numbered matching filter is reported.
- R10: `dec_valid_o` is high exactly one cycle after `frm_valid_i`. `accept_o` is high only in such a cycle and only if some filter matched. When there is no match, `buf_sel_o` and `filt_idx_o` are 0.
- R11: While `rst_n` is low, `dec_valid_o`, `accept_o`, `buf_sel_o` and `filt_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid_i | input | 1 | Strobe: frame identifier is valid |
| frm_id_i | input | 29 | Frame identifier; standard frames use bits [10:0] |
| frm_ide_i | input | 1 | 1 = extended frame, 0 = standard frame |
| flt_id_i | input | 174 | Filter identifiers; filter k is at bits [29k+28:29k] |
| flt_ext_i | input | 6 | Extended-format bit of each filter |
| msk0_i | input | 29 | Mask for buffer 0; bit value 1 = compare this bit |
| msk1_i | input | 29 | Mask for buffer 1 |
| mode0_i | input | 2 | Buffer 0 mode: 00 by filter bit, 01 standard only, 10 extended only, 11 all |
| mode1_i | input | 2 | Buffer 1 mode, same encoding |
| dec_valid_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |
| buf_sel_o | output | 1 | Target buffer |
| filt_idx_o | output | 3 | Index of the matched filter |

## Verification
The assertions check on every cycle that the decision follows the strobe after one cycle, and that an accept never reports a filter outside its buffer's group. They also check that the accept-all mode of buffer 0 always wins, and that frames of the wrong kind are refused when both buffers restrict the frame kind. The sweep over all mode pairs, frame kinds, extended-bit patterns and identifier-hit patterns shows the results that depend on the data: priority between the buffers and within a group, and the choice of index. Directed cases show mask don't-care bits and that the upper bits of standard frames are ignored.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  typedef enum logic [1:0] {
    ACF_BY_FILTER = 2'b00,
    ACF_STD_ONLY  = 2'b01,
    ACF_EXT_ONLY  = 2'b10,
    ACF_TAKE_ALL  = 2'b11
  } acf_mode_e;
endpackage

// File: rtl/acf_filter_cmp.sv
module acf_filter_cmp
  import can_acf_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic [ID_W-1:0] frame_id,
  input  logic            frame_ide,
  input  logic [ID_W-1:0] filt_id,
  input  logic            filt_ext,
  input  logic [ID_W-1:0] mask,
  input  logic [1:0]      mode,
  output logic            hit
);
  localparam logic [ID_W-1:0] STD_SEL = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  logic [ID_W-1:0] eff_mask;
  logic            id_eq;
  logic            kind_ok;

  always_comb begin
    eff_mask = frame_ide ? mask : (mask & STD_SEL);
    id_eq    = ((frame_id ^ filt_id) & eff_mask) == '0;
    unique case (acf_mode_e'(mode))
      ACF_BY_FILTER: kind_ok = (filt_ext == frame_ide);
      ACF_STD_ONLY:  kind_ok = ~frame_ide;
      ACF_EXT_ONLY:  kind_ok = frame_ide;
      default:       kind_ok = 1'b1;
    endcase
    hit = (acf_mode_e'(mode) == ACF_TAKE_ALL) | (kind_ok & id_eq);
  end
endmodule

// File: rtl/acf_prio_pick.sv
module acf_prio_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 3,
  parameter int BASE  = 0
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(BASE + i);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int ID_W     = 29,
  parameter int STD_W    = 11,
  parameter int NUM_FLT  = 6,
  parameter int GRP0_FLT = 2,
  parameter int IDX_W    = $clog2(NUM_FLT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_valid_i,
  input  logic [ID_W-1:0]         frm_id_i,
  input  logic                    frm_ide_i,
  input  logic [NUM_FLT*ID_W-1:0] flt_id_i,
  input  logic [NUM_FLT-1:0]      flt_ext_i,
  input  logic [ID_W-1:0]         msk0_i,
  input  logic [ID_W-1:0]         msk1_i,
  input  logic [1:0]              mode0_i,
  input  logic [1:0]              mode1_i,
  output logic                    dec_valid_o,
  output logic                    accept_o,
  output logic                    buf_sel_o,
  output logic [IDX_W-1:0]        filt_idx_o
);
  localparam int GRP1_FLT = NUM_FLT - GRP0_FLT;

  logic [NUM_FLT-1:0] flt_hit;
  logic               any0, any1;
  logic [IDX_W-1:0]   idx0, idx1;

  logic               nxt_accept;
  logic               nxt_buf;
  logic [IDX_W-1:0]   nxt_idx;

  for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
    acf_filter_cmp #(.ID_W(ID_W), .STD_W(STD_W)) u_cmp (
      .frame_id (frm_id_i),
      .frame_ide(frm_ide_i),
      .filt_id  (flt_id_i[k*ID_W +: ID_W]),
      .filt_ext (flt_ext_i[k]),
      .mask     ((k < GRP0_FLT) ? msk0_i : msk1_i),
      .mode     ((k < GRP0_FLT) ? mode0_i : mode1_i),
      .hit      (flt_hit[k])
    );
  end

  acf_prio_pick #(.N(GRP0_FLT), .IDX_W(IDX_W), .BASE(0)) u_pick0 (
    .hits(flt_hit[GRP0_FLT-1:0]),
    .any (any0),
    .idx (idx0)
  );

  acf_prio_pick #(.N(GRP1_FLT), .IDX_W(IDX_W), .BASE(GRP0_FLT)) u_pick1 (
    .hits(flt_hit[NUM_FLT-1:GRP0_FLT]),
    .any (any1),
    .idx (idx1)
  );

  always_comb begin
    nxt_accept = frm_valid_i & (any0 | any1);
    nxt_buf    = ~any0 & any1;
    if (any0)      nxt_idx = idx0;
    else if (any1) nxt_idx = idx1;
    else           nxt_idx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      buf_sel_o   <= 1'b0;
      filt_idx_o  <= '0;
    end else begin
      dec_valid_o <= frm_valid_i;
      accept_o    <= nxt_accept;
      if (frm_valid_i) begin
        buf_sel_o  <= nxt_buf;
        filt_idx_o <= nxt_idx;
      end
    end
  end
endmodule

// File: rtl/acf_checks.sv
module acf_checks #(
  parameter int NUM_FLT  = 6,
  parameter int GRP0_FLT = 2,
  parameter int IDX_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid_i,
  input logic             frm_ide_i,
  input logic [1:0]       mode0_i,
  input logic [1:0]       mode1_i,
  input logic             dec_valid_o,
  input logic             accept_o,
  input logic             buf_sel_o,
  input logic [IDX_W-1:0] filt_idx_o
);
  p_strobe_decides_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid_i |=> dec_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid_i |=> (!dec_valid_o && !accept_o));

  p_group_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (buf_sel_o ? (32'(filt_idx_o) >= GRP0_FLT && 32'(filt_idx_o) < NUM_FLT)
                            : (32'(filt_idx_o) < GRP0_FLT)));

  p_take_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && mode0_i == 2'b11) |=> (accept_o && !buf_sel_o && filt_idx_o == '0));

  p_std_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && frm_ide_i && mode0_i == 2'b01 && mode1_i == 2'b01) |=> !accept_o);

  p_ext_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !frm_ide_i && mode0_i == 2'b10 && mode1_i == 2'b10) |=> !accept_o);
endmodule

bind can_accept_filter acf_checks #(
  .NUM_FLT (NUM_FLT),
  .GRP0_FLT(GRP0_FLT),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_valid_i(frm_valid_i),
  .frm_ide_i  (frm_ide_i),
  .mode0_i    (mode0_i),
  .mode1_i    (mode1_i),
  .dec_valid_o(dec_valid_o),
  .accept_o   (accept_o),
  .buf_sel_o  (buf_sel_o),
  .filt_idx_o (filt_idx_o)
);

// File: tb/sim_can_accept_filter.sv
module sim_can_accept_filter;
  localparam int ID_W = 29;
  localparam int NF   = 6;
  localparam logic [ID_W-1:0] ALL1 = '1;
  localparam logic [ID_W-1:0] FID  = 29'h15A3C6E9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frm_valid_i;
  logic [ID_W-1:0]   frm_id_i;
  logic              frm_ide_i;
  logic [NF*ID_W-1:0] flt_id_i;
  logic [NF-1:0]     flt_ext_i;
  logic [ID_W-1:0]   msk0_i, msk1_i;
  logic [1:0]        mode0_i, mode1_i;
  logic              dec_valid_o, accept_o, buf_sel_o;
  logic [2:0]        filt_idx_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  can_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i), .frm_id_i(frm_id_i),
    .frm_ide_i(frm_ide_i), .flt_id_i(flt_id_i), .flt_ext_i(flt_ext_i),
    .msk0_i(msk0_i), .msk1_i(msk1_i), .mode0_i(mode0_i), .mode1_i(mode1_i),
    .dec_valid_o(dec_valid_o), .accept_o(accept_o), .buf_sel_o(buf_sel_o),
    .filt_idx_o(filt_idx_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [1:0] m0, input logic [1:0] m1,
                                input logic ide, input logic [5:0] ext,
                                input logic [5:0] hit, output logic acc,
                                output logic bsel, output logic [2:0] idx);
    logic g0, g1, ok;
    logic [1:0] m;
    logic [2:0] i0, i1;
    g0 = 0; g1 = 0; i0 = 0; i1 = 0;
    for (int k = 5; k >= 0; k--) begin
      m  = (k < 2) ? m0 : m1;
      ok = (m == 2'd3) ||
           (hit[k] && ((m == 2'd0 && ext[k] == ide) || (m == 2'd1 && !ide) ||
                       (m == 2'd2 && ide)));
      if (ok) begin
        if (k < 2) begin g0 = 1; i0 = 3'(k); end
        else       begin g1 = 1; i1 = 3'(k); end
      end
    end
    acc  = g0 | g1;
    bsel = !g0 && g1;
    idx  = g0 ? i0 : (g1 ? i1 : 3'd0);
  endfunction

  task automatic send(input logic ide);
    @(negedge clk);
    frm_id_i    = FID;
    frm_ide_i   = ide;
    frm_valid_i = 1'b1;
    @(negedge clk);
    frm_valid_i = 1'b0;
  endtask

  task automatic set_all_filters(input logic [ID_W-1:0] v);
    for (int k = 0; k < NF; k++) flt_id_i[k*ID_W +: ID_W] = v;
  endtask

  initial begin
    logic pacc, pbsel, pend;
    logic [2:0] pidx;
    rst_n = 1'b0;
    frm_valid_i = 0; frm_id_i = '0; frm_ide_i = 0; flt_id_i = '0; flt_ext_i = '0;
    msk0_i = ALL1; msk1_i = ALL1; mode0_i = 0; mode1_i = 0;
    repeat (3) @(negedge clk);
    check("R11 dec_valid in reset", int'(dec_valid_o), 0);
    check("R11 accept in reset", int'(accept_o), 0);
    check("R11 buf in reset", int'(buf_sel_o), 0);
    check("R11 idx in reset", int'(filt_idx_o), 0);
    rst_n = 1'b1;

    // R2: masked-off differing bit
    set_all_filters(FID ^ (29'd1 << 7));
    flt_id_i[0 +: ID_W] = FID ^ (29'd1 << 4);
    msk0_i = ALL1 & ~(29'd1 << 4);
    send(1'b0);
    check("R2 masked bit accept", int'(accept_o), 1);
    check("R2 masked bit idx", int'(filt_idx_o), 0);
    check("R10 decision valid", int'(dec_valid_o), 1);
    @(negedge clk);
    check("R10 no strobe no decision", int'(dec_valid_o), 0);
    msk0_i = ALL1;
    send(1'b0);
    check("R2 compared bit reject", int'(accept_o), 0);
    check("R10 no match zero idx", int'(filt_idx_o), 0);

    // R3: upper bits ignored for standard frames
    flt_id_i[0 +: ID_W] = FID ^ (29'd1 << 20);
    send(1'b0);
    check("R3 std upper bits ignored", int'(accept_o), 1);
    flt_ext_i = 6'b000001;
    send(1'b1);
    check("R3 ext compares upper bits", int'(accept_o), 0);
    msk0_i = ALL1 & ~(29'd1 << 20);
    send(1'b1);
    check("R2 R3 ext masked upper bit", int'(accept_o), 1);
    msk0_i = ALL1; flt_ext_i = '0;

    // R8 R9: both groups hit
    set_all_filters(FID ^ 29'd1);
    flt_id_i[1*ID_W +: ID_W] = FID;
    flt_id_i[3*ID_W +: ID_W] = FID;
    flt_id_i[4*ID_W +: ID_W] = FID;
    send(1'b0);
    check("R8 buffer 0 wins", int'(buf_sel_o), 0);
    check("R9 lowest in group", int'(filt_idx_o), 1);
    flt_id_i[1*ID_W +: ID_W] = FID ^ 29'd1;
    send(1'b0);
    check("R1 group 1 buffer", int'(buf_sel_o), 1);
    check("R9 lowest in group 1", int'(filt_idx_o), 3);

    // Streaming sweep: all modes, kinds, extended bits, hit patterns
    pend = 0; pacc = 0; pbsel = 0; pidx = 0;
    for (int m0 = 0; m0 < 4; m0++)
      for (int m1 = 0; m1 < 4; m1++)
        for (int ide = 0; ide < 2; ide++)
          for (int ext = 0; ext < 64; ext++)
            for (int hit = 0; hit < 64; hit++) begin
              @(negedge clk);
              if (pend) begin
                check("R1 R4 R5 R6 R7 R8 R9 R10 valid", int'(dec_valid_o), 1);
                check("R1 R4 R5 R6 R7 R8 R9 R10 accept", int'(accept_o), int'(pacc));
                check("R1 R8 R10 buffer", int'(buf_sel_o), int'(pbsel));
                check("R1 R7 R9 R10 index", int'(filt_idx_o), int'(pidx));
              end
              for (int k = 0; k < NF; k++)
                flt_id_i[k*ID_W +: ID_W] = hit[k] ? FID : (FID ^ (29'd1 << k));
              flt_ext_i   = 6'(ext);
              mode0_i     = 2'(m0);
              mode1_i     = 2'(m1);
              msk0_i      = ALL1;
              msk1_i      = ALL1;
              frm_id_i    = FID;
              frm_ide_i   = 1'(ide);
              frm_valid_i = 1'b1;
              model(2'(m0), 2'(m1), 1'(ide), 6'(ext), 6'(hit), pacc, pbsel, pidx);
              pend = 1;
            end
    @(negedge clk);
    frm_valid_i = 1'b0;
    check("R10 last valid", int'(dec_valid_o), 1);
    check("R4 R7 R9 last accept", int'(accept_o), int'(pacc));
    check("R9 last index", int'(filt_idx_o), int'(pidx));
    @(negedge clk);
    check("R10 idle after sweep", int'(dec_valid_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule